// File: doc/BRIEF.md
# Hex Text Stream Memory Loader

This block takes a stream of ASCII characters, one per strobe, such as the output of a serial receiver. It turns a plain-text hexadecimal image into byte writes on a memory port. A load is opened by a start-of-text control code and the body is closed by an end-of-text code. Inside the body, each pair of hex digits is one data byte. Whitespace separates the bytes. A dollar sign followed by the letter `A`, four hex digits and a comma moves the write pointer. Without such a marker, the first byte lands at address 0 and each later byte lands one address above the previous one.

After the end code, a trailer made of a dollar sign, the letter `S`, four hex digits and a comma carries the expected 16-bit sum of every data byte. The loader keeps its own running sum. When the trailer comma arrives it raises `done`, and it raises `csum_err` along with it if the two sums differ. Any malformed character during a load stops the load and raises `syntax_err`. A new start code begins a fresh load from any finished or failed state.

Top module: `hexstream_loader`

## Requirements
- R1: Before the first start code (0x02), every character is ignored: no write pulse, and `busy`, `done`, `csum_err` and `syntax_err` stay low.
- R2: A start code (0x02) seen while idle, done or failed sets `busy` high one cycle later. The first data byte of the load is written to address 0 unless an address marker comes before it.
- R3: Two hex digits, either case (`0`-`9`, `A`-`F`, `a`-`f`), give exactly one write pulse with `wr_data` = first digit × 16 + second digit. `wr_en` is high for a single cycle, in the cycle after the second digit's strobe.
- R4: Each following byte is written to the previous byte's address plus one, wrapping at the width of the address.
- R5: The sequence `$`, `A`, four hex digits, `,` loads the write pointer, most significant digit first. The next byte goes to that address, and later bytes count up from it.
- R6: Space (0x20), tab (0x09), LF (0x0A) and CR (0x0D) are skipped between bytes. A completed byte must be followed by whitespace, `$` or the end code (0x03). A hex digit straight after a completed byte is a syntax error.
- R7: During a load, any of the following raises `syntax_err` one cycle after the offending strobe, drops `busy`, and blocks all further writes until the next start code:
  - a character outside the forms above;
  - a lone hex digit followed by whitespace or the end code;
  - a broken address or checksum marker.
- R8: After the end code, whitespace is skipped and the trailer `$`, `S`, four hex digits, `,` is accepted. `done` rises one cycle after the trailer comma and `busy` falls. Any other character after the end code is a syntax error.
- R9: The computed checksum is the sum of all data byte values of the load, modulo 65536. `csum_err` rises together with `done` exactly when the received value differs from it.
- R10: `done`, `csum_err` and `syntax_err` hold until the next start code. That start code clears them and restarts the load with address 0 and a zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Character strobe, one cycle per character |
| rx_char | input | 8 | ASCII character qualified by rx_valid |
| wr_en | output | 1 | Single-cycle byte write strobe |
| wr_addr | output | ADDR_W (16) | Write address |
| wr_data | output | 8 | Write data byte |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Trailer accepted; load finished |
| csum_err | output | 1 | Received checksum differs from computed sum |
| syntax_err | output | 1 | Load aborted on a malformed character |

## Verification
On every cycle, the bound checker checks the following status and strobe rules:
- a write pulse lasts exactly one cycle and only follows a character strobe during a load;
- no write appears in the cycle after the loader was inactive;
- `done`, `syntax_err` and `busy` exclude one another;
- `csum_err` never appears without `done`;
- completion and error flags stay set until a start code arrives.

The directed scenarios cover what needs knowledge of the character stream:
- the exact write addresses under implied and explicit addressing;
- the decoded byte values in both letter cases;
- the modulo-65536 wrap of the checksum;
- the specific malformed inputs that must abort a load.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_BODY,
      S_NIB,
      S_SEP,
      S_AMARK,
      S_ADIG,
      S_ACOM,
      S_TAIL,
      S_SMARK,
      S_SDIG,
      S_SCOM,
      S_DONE,
      S_ERR
   } hsl_state_e;

   typedef struct packed {
      logic       hex;
      logic [3:0] val;
      logic       ws;
      logic       stx;
      logic       etx;
      logic       dollar;
      logic       comma;
      logic       addr_key;
      logic       sum_key;
   } hsl_cls_t;

endpackage

// File: rtl/hsl_char_class.sv
module hsl_char_class
   import hsl_pkg::*;
#(
   parameter logic [7:0] START_CODE   = 8'h02,
   parameter logic [7:0] END_CODE     = 8'h03,
   parameter logic [7:0] ADDR_KEY     = 8'h41,
   parameter logic [7:0] SUM_KEY      = 8'h53,
   parameter bit         ACCEPT_LOWER = 1'b1
) (
   input  logic [7:0] ch,
   output hsl_cls_t   cls
);

   logic is_dig;
   logic is_uc;
   logic is_lc;

   assign is_dig = (ch >= 8'h30) && (ch <= 8'h39);
   assign is_uc  = (ch >= 8'h41) && (ch <= 8'h46);

   generate
      if (ACCEPT_LOWER) begin : g_lower
         assign is_lc = (ch >= 8'h61) && (ch <= 8'h66);
      end else begin : g_upper_only
         assign is_lc = 1'b0;
      end
   endgenerate

   // letters of either case have low nibble 1..6, so +9 maps to 10..15
   always_comb begin
      cls.hex      = is_dig || is_uc || is_lc;
      cls.val      = is_dig ? ch[3:0] : (ch[3:0] + 4'd9);
      cls.ws       = (ch == 8'h20) || (ch == 8'h09) || (ch == 8'h0A) || (ch == 8'h0D);
      cls.stx      = (ch == START_CODE);
      cls.etx      = (ch == END_CODE);
      cls.dollar   = (ch == 8'h24);
      cls.comma    = (ch == 8'h2C);
      cls.addr_key = (ch == ADDR_KEY);
      cls.sum_key  = (ch == SUM_KEY);
   end

endmodule

// File: rtl/hsl_field.sv
module hsl_field #(
   parameter int DIGITS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  push,
   input  logic [3:0]            nib,
   output logic [4*DIGITS-1:0]   value,
   output logic                  last
);

   localparam int W  = 4 * DIGITS;
   localparam int CW = $clog2(DIGITS + 1);

   generate
      if (DIGITS < 2) begin : g_bad_digits
         $error("hsl_field needs at least two digits");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   // the push that arrives while last is high completes the field
   assign last = (cnt_q == CW'(DIGITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         value <= '0;
         cnt_q <= '0;
      end else if (push) begin
         value <= {value[W-5:0], nib};
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/hsl_sum_acc.sv
module hsl_sum_acc #(
   parameter int SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [7:0]       byte_in,
   output logic [SUM_W-1:0] sum
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (clr) begin
         sum <= '0;
      end else if (add) begin
         sum <= sum + SUM_W'(byte_in);
      end
   end

endmodule

// File: rtl/hsl_seq.sv
module hsl_seq
   import hsl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SUM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  hsl_cls_t          cls,
   input  logic [7:0]        byte_part,
   input  logic              byte_last,
   input  logic [ADDR_W-1:0] addr_val,
   input  logic              addr_last,
   input  logic [SUM_W-1:0]  sum_rx,
   input  logic              sum_last,
   input  logic [SUM_W-1:0]  sum_acc,
   output logic              byte_clr,
   output logic              byte_push,
   output logic              addr_clr,
   output logic              addr_push,
   output logic              sumf_clr,
   output logic              sumf_push,
   output logic              acc_clr,
   output logic              acc_add,
   output logic [7:0]        byte_full,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              busy,
   output logic              done,
   output logic              csum_err,
   output logic              syntax_err
);

   hsl_state_e        state_q, state_d;
   logic [ADDR_W-1:0] ptr_q;
   logic              start, wr_go, set_addr, fin, fail;

   assign byte_full = {byte_part[3:0], cls.val};

   always_comb begin
      state_d   = state_q;
      start     = 1'b0;
      wr_go     = 1'b0;
      set_addr  = 1'b0;
      fin       = 1'b0;
      fail      = 1'b0;
      byte_push = 1'b0;
      byte_clr  = 1'b0;
      addr_push = 1'b0;
      addr_clr  = 1'b0;
      sumf_push = 1'b0;
      sumf_clr  = 1'b0;
      if (valid) begin
         case (state_q)
            S_IDLE, S_DONE, S_ERR: begin
               if (cls.stx) start = 1'b1;
            end
            S_BODY: begin
               if (cls.hex) begin
                  byte_push = 1'b1;
                  state_d   = S_NIB;
               end else if (cls.ws) begin
                  state_d = S_BODY;
               end else if (cls.dollar) begin
                  state_d = S_AMARK;
               end else if (cls.etx) begin
                  state_d = S_TAIL;
               end else begin
                  fail = 1'b1;
               end
            end
            S_NIB: begin
               if (cls.hex && byte_last) begin
                  wr_go   = 1'b1;
                  state_d = S_SEP;
               end else if (cls.hex) begin
                  byte_push = 1'b1;
               end else begin
                  fail = 1'b1;
               end
            end
            S_SEP: begin
               if (cls.ws)          state_d = S_BODY;
               else if (cls.dollar) state_d = S_AMARK;
               else if (cls.etx)    state_d = S_TAIL;
               else                 fail    = 1'b1;
            end
            S_AMARK: begin
               if (cls.addr_key) begin
                  addr_clr = 1'b1;
                  state_d  = S_ADIG;
               end else begin
                  fail = 1'b1;
               end
            end
            S_ADIG: begin
               if (cls.hex) begin
                  addr_push = 1'b1;
                  if (addr_last) state_d = S_ACOM;
               end else begin
                  fail = 1'b1;
               end
            end
            S_ACOM: begin
               if (cls.comma) begin
                  set_addr = 1'b1;
                  state_d  = S_BODY;
               end else begin
                  fail = 1'b1;
               end
            end
            S_TAIL: begin
               if (cls.ws)          state_d = S_TAIL;
               else if (cls.dollar) state_d = S_SMARK;
               else                 fail    = 1'b1;
            end
            S_SMARK: begin
               if (cls.sum_key) begin
                  sumf_clr = 1'b1;
                  state_d  = S_SDIG;
               end else begin
                  fail = 1'b1;
               end
            end
            S_SDIG: begin
               if (cls.hex) begin
                  sumf_push = 1'b1;
                  if (sum_last) state_d = S_SCOM;
               end else begin
                  fail = 1'b1;
               end
            end
            S_SCOM: begin
               if (cls.comma) begin
                  fin     = 1'b1;
                  state_d = S_DONE;
               end else begin
                  fail = 1'b1;
               end
            end
            default: fail = 1'b1;
         endcase
      end
      if (start) begin
         state_d  = S_BODY;
         byte_clr = 1'b1;
      end
      if (wr_go) byte_clr = 1'b1;
      if (fail)  state_d  = S_ERR;
   end

   assign acc_clr = start;
   assign acc_add = wr_go;
   assign busy    = (state_q != S_IDLE) && (state_q != S_DONE) && (state_q != S_ERR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         ptr_q      <= '0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         done       <= 1'b0;
         csum_err   <= 1'b0;
         syntax_err <= 1'b0;
      end else begin
         state_q <= state_d;
         wr_en   <= wr_go;
         if (wr_go) begin
            wr_addr <= ptr_q;
            wr_data <= byte_full;
            ptr_q   <= ptr_q + ADDR_W'(1);
         end
         if (set_addr) ptr_q <= addr_val;
         if (start) begin
            ptr_q      <= '0;
            done       <= 1'b0;
            csum_err   <= 1'b0;
            syntax_err <= 1'b0;
         end
         if (fin) begin
            done     <= 1'b1;
            csum_err <= (sum_rx != sum_acc);
         end
         if (fail) syntax_err <= 1'b1;
      end
   end

endmodule

// File: rtl/hexstream_loader.sv
module hexstream_loader
   import hsl_pkg::*;
#(
   parameter int         ADDR_W       = 16,
   parameter int         SUM_W        = 16,
   parameter logic [7:0] START_CODE   = 8'h02,
   parameter logic [7:0] END_CODE     = 8'h03,
   parameter bit         ACCEPT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_char,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              busy,
   output logic              done,
   output logic              csum_err,
   output logic              syntax_err
);

   localparam int ADDR_DIGITS = ADDR_W / 4;
   localparam int SUM_DIGITS  = SUM_W / 4;

   generate
      if ((ADDR_W % 4) != 0 || ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must be a multiple of 4 and at least 8");
      end
      if ((SUM_W % 4) != 0 || SUM_W < 8) begin : g_bad_sum_w
         $error("SUM_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   hsl_cls_t          cls;
   logic [7:0]        byte_part, byte_full;
   logic              byte_last, byte_clr, byte_push;
   logic [ADDR_W-1:0] addr_val;
   logic              addr_last, addr_clr, addr_push;
   logic [SUM_W-1:0]  sum_rx, sum_acc;
   logic              sum_last, sumf_clr, sumf_push;
   logic              acc_clr, acc_add;

   hsl_char_class #(
      .START_CODE  (START_CODE),
      .END_CODE    (END_CODE),
      .ADDR_KEY    (8'h41),
      .SUM_KEY     (8'h53),
      .ACCEPT_LOWER(ACCEPT_LOWER)
   ) u_class (
      .ch (rx_char),
      .cls(cls)
   );

   hsl_field #(.DIGITS(2)) u_byte_f (
      .clk(clk), .rst_n(rst_n), .clr(byte_clr), .push(byte_push),
      .nib(cls.val), .value(byte_part), .last(byte_last)
   );

   hsl_field #(.DIGITS(ADDR_DIGITS)) u_addr_f (
      .clk(clk), .rst_n(rst_n), .clr(addr_clr), .push(addr_push),
      .nib(cls.val), .value(addr_val), .last(addr_last)
   );

   hsl_field #(.DIGITS(SUM_DIGITS)) u_sum_f (
      .clk(clk), .rst_n(rst_n), .clr(sumf_clr), .push(sumf_push),
      .nib(cls.val), .value(sum_rx), .last(sum_last)
   );

   hsl_sum_acc #(.SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
      .byte_in(byte_full), .sum(sum_acc)
   );

   hsl_seq #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (rx_valid),
      .cls       (cls),
      .byte_part (byte_part),
      .byte_last (byte_last),
      .addr_val  (addr_val),
      .addr_last (addr_last),
      .sum_rx    (sum_rx),
      .sum_last  (sum_last),
      .sum_acc   (sum_acc),
      .byte_clr  (byte_clr),
      .byte_push (byte_push),
      .addr_clr  (addr_clr),
      .addr_push (addr_push),
      .sumf_clr  (sumf_clr),
      .sumf_push (sumf_push),
      .acc_clr   (acc_clr),
      .acc_add   (acc_add),
      .byte_full (byte_full),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .busy      (busy),
      .done      (done),
      .csum_err  (csum_err),
      .syntax_err(syntax_err)
   );

endmodule

// File: rtl/hsl_checker.sv
module hsl_checker #(
   parameter logic [7:0] START_CODE = 8'h02
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] rx_char,
   input logic       wr_en,
   input logic       busy,
   input logic       done,
   input logic       csum_err,
   input logic       syntax_err
);

   logic restart;
   assign restart = rx_valid && (rx_char == START_CODE);

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !wr_en); // R1
   AST_WR_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R2
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R3
   AST_WR_FROM_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rx_valid)); // R3
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      syntax_err |-> (!busy && !wr_en && !done)); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_CSUM_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      csum_err |-> done); // R9
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !restart) |=> done); // R10
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (syntax_err && !restart) |=> syntax_err); // R10
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !busy) |=> (busy && !done && !syntax_err && !csum_err)); // R10

endmodule

bind hexstream_loader hsl_checker #(.START_CODE(START_CODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_char   (rx_char),
   .wr_en     (wr_en),
   .busy      (busy),
   .done      (done),
   .csum_err  (csum_err),
   .syntax_err(syntax_err)
);

// File: tb/tb_hexstream_loader.sv
`timescale 1ns/1ps
module tb_hexstream_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_char = 8'h00;
   logic        wr_en, busy, done, csum_err, syntax_err;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;

   int total = 0;
   int fails = 0;
   int n_log = 0;
   int n_exp = 0;
   int log_a [300];
   int log_d [300];
   int exp_a [300];
   int exp_d [300];

   always #2 clk = ~clk;

   hexstream_loader dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
      .done(done), .csum_err(csum_err), .syntax_err(syntax_err)
   );

   // capture writes 1 ns after each rising edge
   always begin
      @(posedge clk);
      #1;
      if (wr_en && n_log < 300) begin
         log_a[n_log] = int'(wr_addr);
         log_d[n_log] = int'(wr_data);
         n_log++;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int expv);
      total++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic send_char(input logic [7:0] c);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_char  = c;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_char  = 8'h00;
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send_char(s[i]);
   endtask

   task automatic begin_load();
      n_log = 0;
      n_exp = 0;
      send_char(8'h02);
   endtask

   task automatic expect_wr(input int a, input int d);
      exp_a[n_exp] = a;
      exp_d[n_exp] = d;
      n_exp++;
   endtask

   task automatic check_log(input string req);
      chk(req, "write count", n_log, n_exp);
      for (int i = 0; i < n_exp && i < n_log; i++) begin
         chk(req, $sformatf("addr of write %0d", i), log_a[i], exp_a[i]);
         chk(req, $sformatf("data of write %0d", i), log_d[i], exp_d[i]);
      end
   endtask

   task automatic check_status(input string req, input int b, input int d, input int c, input int s);
      chk(req, "busy", int'(busy), b);
      chk(req, "done", int'(done), d);
      chk(req, "csum_err", int'(csum_err), c);
      chk(req, "syntax_err", int'(syntax_err), s);
   endtask

   task automatic t_reset();
      check_status("R1", 0, 0, 0, 0);
      chk("R1", "wr_en after reset", int'(wr_en), 0);
   endtask

   task automatic t_preamble();
      n_log = 0;
      send_str("xyz 12 AB $A0010,");
      send_char(8'h03);
      check_status("R1", 0, 0, 0, 0);
      chk("R1", "writes before start", n_log, 0);
   endtask

   task automatic t_hello();
      string msg = "Hello, World";
      int sum = 0;
      begin_load();
      check_status("R2", 1, 0, 0, 0);
      send_str("$A1000, 48 65 6C 6C 6F 2C 20 57 6F 72 6C 64 0A");
      for (int i = 0; i < msg.len(); i++) begin
         expect_wr(16'h1000 + i, int'(msg[i]));
         sum += int'(msg[i]);
      end
      expect_wr(16'h100C, 8'h0A);
      sum += 8'h0A;
      chk("R9", "reference sum", sum & 16'hFFFF, 16'h0452);
      send_char(8'h03);
      send_str("$S0452,");
      check_log("R5 R4 R3");
      check_status("R8", 0, 1, 0, 0);
   endtask

   task automatic t_bad_csum();
      begin_load();
      send_str("01 02");
      send_char(8'h03);
      send_str("$S0004,");
      expect_wr(0, 1);
      expect_wr(1, 2);
      check_log("R2");
      check_status("R9", 0, 1, 1, 0);
   endtask

   task automatic t_lower_ws();
      begin_load();
      check_status("R10", 1, 0, 0, 0);
      send_str("ab\tCD\r\n0f ");
      send_char(8'h03);
      send_str(" \n$S0187,");
      expect_wr(0, 8'hAB);
      expect_wr(1, 8'hCD);
      expect_wr(2, 8'h0F);
      check_log("R6 R3");
      check_status("R8", 0, 1, 0, 0);
   endtask

   task automatic t_single_digit();
      begin_load();
      send_str("1 ");
      check_status("R7", 0, 0, 0, 1);
      send_str("22 33");
      send_char(8'h03);
      send_str("$S0055,");
      chk("R7", "writes after lone digit", n_log, 0);
      check_status("R7", 0, 0, 0, 1);
   endtask

   task automatic t_lone_etx();
      begin_load();
      send_str("44 5");
      send_char(8'h03);
      expect_wr(0, 8'h44);
      check_log("R7");
      check_status("R7", 0, 0, 0, 1);
   endtask

   task automatic t_bad_char();
      begin_load();
      send_str("12 G3 45");
      expect_wr(0, 8'h12);
      check_log("R7");
      check_status("R7", 0, 0, 0, 1);
   endtask

   task automatic t_adjacent();
      begin_load();
      send_str("1234");
      expect_wr(0, 8'h12);
      check_log("R6");
      check_status("R6", 0, 0, 0, 1);
   endtask

   task automatic t_bad_marker();
      begin_load();
      send_str("$B0001,");
      check_status("R7", 0, 0, 0, 1);
   endtask

   task automatic t_marker_mid();
      begin_load();
      check_status("R10", 1, 0, 0, 0);
      send_str("11 $A00f0,22 33$AFFFF,44 55");
      send_char(8'h03);
      send_str("$S00FF,");
      expect_wr(0, 8'h11);
      expect_wr(16'h00F0, 8'h22);
      expect_wr(16'h00F1, 8'h33);
      expect_wr(16'hFFFF, 8'h44);
      expect_wr(0, 8'h55);
      check_log("R5 R4");
      check_status("R9", 0, 1, 0, 0);
   endtask

   task automatic t_tail_err();
      begin_load();
      send_str("05");
      send_char(8'h03);
      send_str(" x");
      check_status("R8", 0, 0, 0, 1);
   endtask

   task automatic t_wrap();
      begin_load();
      for (int i = 0; i < 258; i++) begin
         send_str("FF ");
         expect_wr(i, 8'hFF);
      end
      send_char(8'h03);
      send_str("$S00FE,");
      check_log("R4");
      check_status("R9", 0, 1, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_preamble();
      t_hello();
      t_bad_csum();
      t_lower_ws();
      t_single_digit();
      t_lone_etx();
      t_bad_char();
      t_adjacent();
      t_bad_marker();
      t_marker_mid();
      t_tail_err();
      t_wrap();
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule